// File: doc/BRIEF.md
# USB Endpoint-0 Interrupt Status Unit

This block holds the interrupt status and interrupt mask registers of a USB device controller. It covers control endpoint 0 and the general bus events. The USB protocol engine delivers each event as a one-cycle strobe. The unit latches every strobe into a sticky status bit. Software reads that bit and clears it by writing a 1 to its position. A mask register selects which pending bits drive the single interrupt request line.

One status bit, the configuration-change bit, has its own behaviour:

- It is set each time a SET_CONFIGURATION or SET_INTERFACE request completes, including a request that changes nothing.
- With the debug input high, it is also set when the device's function address changes.
- While the bit is pending, the unit raises a force-NAK output. The packet handler of the active endpoints uses it to answer every IN and OUT packet with NAK until software has prepared its FIFOs and cleared the bit.

Top module: `usb_ep0_irq_unit`

## Requirements
- R1: After reset, both registers read zero, and `irq` and `force_nak` are low.
- R2: A pulse on `evt_pulse[i]` (i from 0 to 15) sets status bit i on the next clock edge. The bit layout is: 15 vendor request, 14 frame match, 13 anticipated start-of-frame, 12 start-of-frame, 11 wake change, 10 resume, 9 suspend, 8 bus reset, 7 OUT end of transfer, 6 OUT end of packet, 5 OUT FIFO level, 4 IN end of transfer, 3 IN end of packet, 2 unhalt, 1 halt, 0 IN FIFO level. Bit 16 is the configuration-change bit.
- R3: A write with `reg_sel`=0 selects the status register. It clears each status bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged.
- R4: If a set and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Reserved bits 31 to 17 of both registers always read zero, and writes to them are ignored.
- R6: A pulse on `cfg_req_done` sets status bit 16. A repeated pulse sets it again after software has cleared it.
- R7: `force_nak` is high exactly while status bit 16 is 1.
- R8: While `dbg_en` is high, a change of `func_addr` from its value in the previous cycle sets status bit 16. While `dbg_en` is low, address changes have no effect.
- R9: `irq` is the OR over all bits of (status AND mask). It is registered, so it follows the registers one cycle later.
- R10: A status bit latches even when its mask bit is 0, and it stays readable.
- R11: A write with `reg_sel`=1 loads bits 16 to 0 of the mask register. `reg_rdata` shows the status register when `reg_sel`=0 and the mask register when `reg_sel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Register select: 0 = status, 1 = mask |
| reg_wr_en | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| evt_pulse | input | 16 | One-cycle event strobes for status bits 15 to 0 |
| cfg_req_done | input | 1 | Strobe: SET_CONFIGURATION or SET_INTERFACE request completed |
| dbg_en | input | 1 | Debug mode: an address change counts as a configuration change |
| func_addr | input | 7 | Current USB function address |
| irq | output | 1 | Registered, masked interrupt request |
| force_nak | output | 1 | NAK all active-endpoint packets while the configuration change is pending |

## Verification
The bench builds the unit with its default parameters: 16 event bits, a 7-bit address and a 32-bit register word. At that size every one of the 17 live status bits can be driven one at a time. Each bit is checked for set, clear, set/clear collision and masked interrupt response. Reserved-bit writes are also checked.

An arithmetic sweep of several hundred mixed cycles then combines event strobes, partial clears, mask rewrites, configuration strobes and address changes in debug mode. Every cycle is compared against a bench model of the registers.

// File: rtl/usb_ep0_irq_pkg.sv
package usb_ep0_irq_pkg;
  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_MASK   = 1'b1
  } reg_sel_e;

  // generic helpers, width fixed at the widest live register the unit allows
  localparam int MAX_LIVE = 32;

  function automatic logic [MAX_LIVE-1:0] sticky_next(
    input logic [MAX_LIVE-1:0] cur,
    input logic [MAX_LIVE-1:0] set_v,
    input logic [MAX_LIVE-1:0] clr_v
  );
    return set_v | (cur & ~clr_v);
  endfunction

  function automatic logic any_enabled(
    input logic [MAX_LIVE-1:0] sts,
    input logic [MAX_LIVE-1:0] msk
  );
    return |(sts & msk);
  endfunction
endpackage

// File: rtl/usb_ep0_addr_watch.sv
module usb_ep0_addr_watch #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_en,
  input  logic [ADDR_W-1:0] func_addr,
  output logic              addr_chg
);
  logic [ADDR_W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= func_addr;
  end

  assign addr_chg = dbg_en && (func_addr != prev_q);
endmodule

// File: rtl/usb_ep0_sts_bank.sv
module usb_ep0_sts_bank
  import usb_ep0_irq_pkg::*;
#(
  parameter int LIVE_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LIVE_W-1:0] set_vec,
  input  logic [LIVE_W-1:0] clr_vec,
  output logic [LIVE_W-1:0] sts_q
);
  logic [MAX_LIVE-1:0] nxt_wide;

  always_comb begin
    nxt_wide = sticky_next(MAX_LIVE'(sts_q), MAX_LIVE'(set_vec), MAX_LIVE'(clr_vec));
  end

  for (genvar b = 0; b < LIVE_W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q[b] <= 1'b0;
      else        sts_q[b] <= nxt_wide[b];
    end
  end

  if (MAX_LIVE > LIVE_W) begin : g_unused
    logic unused_hi;
    assign unused_hi = |nxt_wide[MAX_LIVE-1:LIVE_W];
  end
endmodule

// File: rtl/usb_ep0_irq_merge.sv
module usb_ep0_irq_merge
  import usb_ep0_irq_pkg::*;
#(
  parameter int LIVE_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LIVE_W-1:0] sts,
  input  logic [LIVE_W-1:0] msk,
  output logic              irq
);
  logic pend;

  assign pend = any_enabled(MAX_LIVE'(sts), MAX_LIVE'(msk));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= pend;
  end
endmodule

// File: rtl/usb_ep0_irq_unit.sv
module usb_ep0_irq_unit
  import usb_ep0_irq_pkg::*;
#(
  parameter int EVT_W  = 16,
  parameter int ADDR_W = 7,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [EVT_W-1:0]  evt_pulse,
  input  logic              cfg_req_done,
  input  logic              dbg_en,
  input  logic [ADDR_W-1:0] func_addr,
  output logic              irq,
  output logic              force_nak
);
  localparam int LIVE_W  = EVT_W + 1;
  localparam int CFG_BIT = EVT_W;
  localparam int RSV_W   = REG_W - LIVE_W;

  // named internal events
  logic              addr_chg;
  logic              cfg_set;
  logic              wr_status;
  logic              wr_mask;
  logic [LIVE_W-1:0] set_vec;
  logic [LIVE_W-1:0] clr_vec;
  logic [LIVE_W-1:0] sts_q;
  logic [LIVE_W-1:0] msk_q;

  assign wr_status = reg_wr_en && (reg_sel_e'(reg_sel) == SEL_STATUS);
  assign wr_mask   = reg_wr_en && (reg_sel_e'(reg_sel) == SEL_MASK);
  assign cfg_set   = cfg_req_done || addr_chg;
  assign set_vec   = {cfg_set, evt_pulse};
  assign clr_vec   = wr_status ? reg_wdata[LIVE_W-1:0] : '0;

  usb_ep0_addr_watch #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .dbg_en    (dbg_en),
    .func_addr (func_addr),
    .addr_chg  (addr_chg)
  );

  usb_ep0_sts_bank #(.LIVE_W(LIVE_W)) u_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .sts_q   (sts_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       msk_q <= '0;
    else if (wr_mask) msk_q <= reg_wdata[LIVE_W-1:0];
  end

  usb_ep0_irq_merge #(.LIVE_W(LIVE_W)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .sts   (sts_q),
    .msk   (msk_q),
    .irq   (irq)
  );

  assign force_nak = sts_q[CFG_BIT];
  assign reg_rdata = {{RSV_W{1'b0}}, (reg_sel ? msk_q : sts_q)};

  logic unused_rsv;
  assign unused_rsv = |reg_wdata[REG_W-1:LIVE_W];
endmodule

// File: rtl/usb_ep0_irq_unit_chk.sv
module usb_ep0_irq_unit_chk #(
  parameter int LIVE_W = 17,
  parameter int REG_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LIVE_W-1:0] set_vec,
  input logic [LIVE_W-1:0] clr_vec,
  input logic [LIVE_W-1:0] sts_q,
  input logic [LIVE_W-1:0] msk_q,
  input logic              cfg_req_done,
  input logic              addr_chg,
  input logic              force_nak,
  input logic              irq,
  input logic [REG_W-1:0]  reg_rdata
);
  localparam int CFG_BIT = LIVE_W - 1;

  // R2: every strobed bit is pending on the next cycle
  a_r2_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((sts_q & $past(set_vec)) == $past(set_vec)));

  // R3: cleared bits with no concurrent set read zero afterwards
  a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((sts_q & $past(clr_vec & ~set_vec)) == '0));

  // R4: a collision keeps the bit set
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & clr_vec) != '0) |=> ((sts_q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));

  // R5: reserved bits never read non-zero
  a_r5_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:LIVE_W] == '0);

  // R6: configuration request always marks the change bit
  a_r6_cfg_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_done |=> sts_q[CFG_BIT]);

  // R7: NAK forcing only starts from a set of the change bit
  a_r7_nak_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_nak) |-> $past(set_vec[CFG_BIT]));

  // R8: debug address change marks the change bit
  a_r8_addr_chg: assert property (@(posedge clk) disable iff (!rst_n)
    addr_chg |=> sts_q[CFG_BIT]);

  // R9: request line follows masked status one cycle later
  a_r9_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |($past(sts_q & msk_q))));
endmodule

bind usb_ep0_irq_unit usb_ep0_irq_unit_chk #(.LIVE_W(LIVE_W), .REG_W(REG_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .set_vec      (set_vec),
  .clr_vec      (clr_vec),
  .sts_q        (sts_q),
  .msk_q        (msk_q),
  .cfg_req_done (cfg_req_done),
  .addr_chg     (addr_chg),
  .force_nak    (force_nak),
  .irq          (irq),
  .reg_rdata    (reg_rdata)
);

// File: tb/usb_ep0_irq_unit_test.sv
module usb_ep0_irq_unit_test;
  localparam int EVT_W  = 16;
  localparam int ADDR_W = 7;
  localparam int REG_W  = 32;
  localparam int LIVE_W = EVT_W + 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              reg_sel;
  logic              reg_wr_en;
  logic [REG_W-1:0]  reg_wdata;
  logic [REG_W-1:0]  reg_rdata;
  logic [EVT_W-1:0]  evt_pulse;
  logic              cfg_req_done;
  logic              dbg_en;
  logic [ADDR_W-1:0] func_addr;
  logic              irq;
  logic              force_nak;

  always #4 clk = ~clk;

  usb_ep0_irq_unit #(.EVT_W(EVT_W), .ADDR_W(ADDR_W), .REG_W(REG_W)) uut (
    .clk (clk), .rst_n (rst_n), .reg_sel (reg_sel), .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .evt_pulse (evt_pulse),
    .cfg_req_done (cfg_req_done), .dbg_en (dbg_en), .func_addr (func_addr),
    .irq (irq), .force_nak (force_nak)
  );

  int vecs = 0;
  int bad  = 0;
  logic [LIVE_W-1:0] m_sts = '0;
  logic [LIVE_W-1:0] m_msk = '0;
  logic              m_irq = 1'b0;
  logic [ADDR_W-1:0] m_prev = '0;

  task automatic check(input string tag, input string what,
                       input logic [REG_W-1:0] act, input logic [REG_W-1:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, advance model at posedge, compare at next negedge
  task automatic step(input string tag, input logic [EVT_W-1:0] ev, input logic cfg,
                      input logic wr, input logic sel, input logic [REG_W-1:0] wd,
                      input logic dbg, input logic [ADDR_W-1:0] fa);
    logic [LIVE_W-1:0] setv, clrv;
    evt_pulse = ev; cfg_req_done = cfg; reg_wr_en = wr; reg_sel = sel;
    reg_wdata = wd; dbg_en = dbg; func_addr = fa;
    setv = {cfg | (dbg && (fa != m_prev)), ev};
    clrv = (wr && !sel) ? wd[LIVE_W-1:0] : '0;
    @(posedge clk);
    m_irq = |(m_sts & m_msk);
    m_sts = setv | (m_sts & ~clrv);
    if (wr && sel) m_msk = wd[LIVE_W-1:0];
    m_prev = fa;
    @(negedge clk);
    evt_pulse = '0; cfg_req_done = 1'b0; reg_wr_en = 1'b0;
    check(tag, "rdata", reg_rdata, {{(REG_W-LIVE_W){1'b0}}, (sel ? m_msk : m_sts)});
    check(tag, "irq", REG_W'(irq), REG_W'(m_irq));
    check(tag, "force_nak", REG_W'(force_nak), REG_W'(m_sts[LIVE_W-1]));
  endtask

  task automatic idle(input string tag, input logic sel);
    step(tag, '0, 1'b0, 1'b0, sel, '0, dbg_en, func_addr);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_sel = 1'b0; reg_wr_en = 1'b0; reg_wdata = '0;
    evt_pulse = '0; cfg_req_done = 1'b0; dbg_en = 1'b0; func_addr = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", "status", reg_rdata, '0);
    reg_sel = 1'b1; #1;
    check("R1", "mask", reg_rdata, '0);
    check("R1", "irq", REG_W'(irq), '0);
    check("R1", "force_nak", REG_W'(force_nak), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2, R10, R3: each event bit alone with mask zero, then clear it
    for (int i = 0; i < EVT_W; i++) begin
      step("R2", EVT_W'(1) << i, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
      idle("R10", 1'b0);
      step("R3", '0, 1'b0, 1'b1, 1'b0, ~(REG_W'(1) << i), 1'b0, '0);
      step("R3", '0, 1'b0, 1'b1, 1'b0, REG_W'(1) << i, 1'b0, '0);
    end

    // R5, R11: mask with reserved bits written
    step("R5", '0, 1'b0, 1'b1, 1'b1, '1, 1'b0, '0);
    step("R11", '0, 1'b0, 1'b1, 1'b1, 32'h0001_2345, 1'b0, '0);
    step("R11", '0, 1'b0, 1'b1, 1'b1, '1, 1'b0, '0);

    // R9, R4: each live bit with full mask; collision with clear
    for (int i = 0; i < LIVE_W; i++) begin
      if (i < EVT_W) step("R9", EVT_W'(1) << i, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
      else           step("R6", '0, 1'b1, 1'b0, 1'b0, '0, 1'b0, '0);
      idle("R9", 1'b0);
      if (i < EVT_W) step("R4", EVT_W'(1) << i, 1'b0, 1'b1, 1'b0, REG_W'(1) << i, 1'b0, '0);
      else           step("R4", '0, 1'b1, 1'b1, 1'b0, REG_W'(1) << i, 1'b0, '0);
      step("R3", '0, 1'b0, 1'b1, 1'b0, '1, 1'b0, '0);
      idle("R9", 1'b0);
    end

    // R6, R7: repeated configuration requests set the bit every time
    repeat (3) begin
      step("R6", '0, 1'b1, 1'b0, 1'b0, '0, 1'b0, '0);
      step("R7", '0, 1'b1, 1'b0, 1'b0, '0, 1'b0, '0);
      step("R7", '0, 1'b0, 1'b1, 1'b0, REG_W'(1) << EVT_W, 1'b0, '0);
      idle("R7", 1'b0);
    end

    // R8: address change with and without debug
    step("R8", '0, 1'b0, 1'b0, 1'b0, '0, 1'b0, 7'h05);
    idle("R8", 1'b0);
    step("R8", '0, 1'b0, 1'b0, 1'b0, '0, 1'b1, 7'h05);
    step("R8", '0, 1'b0, 1'b0, 1'b0, '0, 1'b1, 7'h2a);
    step("R8", '0, 1'b0, 1'b1, 1'b0, '1, 1'b1, 7'h2a);
    idle("R8", 1'b0);

    // mixed arithmetic sweep
    for (int k = 0; k < 400; k++) begin
      logic [31:0] h;
      h = (k * 32'd2654435761) ^ (k << 7);
      step("R9", h[15:0] & h[31:16], (h[5:0] == 6'd7), h[9], h[10], {h[15:0], h[31:16]},
           h[3], (h[2:0] == 3'd0) ? h[14:8] : func_addr);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule